// File: doc/BRIEF.md
# Epoch-Aware Hit Stream Concentrator

The concentrator takes several time-sorted record streams, one per front-end encoder, and merges them into a single stream that is still sorted in time. Each input stream carries two kinds of record. A hit record holds a channel address and a timestamp offset within the current epoch. An epoch marker record opens the next epoch. Every input sends its own copy of each epoch marker. The merged output carries that marker only once, followed by the hits of that epoch in ascending offset order.

The block does not decide on a hit until every input has a record waiting. Only then can it be sure that no smaller offset is still on its way. When every waiting record is a marker, the epoch is closed: one marker goes out, numbered from an internal epoch counter, and all inputs advance together. Each hit on the output carries its input index above the channel address, so the origin of every hit survives the merge. If an input's marker carries an unexpected epoch number, a sticky error output is set and that marker is treated as the expected one.

All inputs and the output use valid/ready handshakes. The output is formed combinationally from the waiting input records. A record moves from an input to the output in the same cycle in which the output is accepted.

Top module: `hit_merge`

## Requirements
- R1: Input record layout, IW = 1+CH_W+OFF_W bits. Bit IW-1 is 1 for a marker and 0 for a hit. A hit holds the channel in bits [CH_W+OFF_W-1:OFF_W] and the offset in bits [OFF_W-1:0]. A marker holds the epoch number in bits [EP_W-1:0] and zeros above it.
- R2: out_valid is high only while every input has in_valid high. While any input is not valid, no in_ready is raised.
- R3: When at least one waiting record is a hit, the hit with the smallest offset is taken. Equal offsets go to the lowest input index. Inputs with a waiting marker are not consumed.
- R4: An output hit is {1'b0, input index (IDX_W bits), channel, offset}, and only the input it came from sees in_ready.
- R5: When every waiting record is a marker, one output marker {1'b1, zeros, epoch} is emitted and all inputs are consumed together. The epoch is 0 after reset and goes up by one with each emitted marker.
- R6: A marker whose epoch differs from the expected one sets err. err stays set until reset. That marker is still consumed, and the output carries the expected epoch number.
- R7: An epoch with no hits still produces its marker, so two markers appear back to back on the output.
- R8: While out_valid is high and out_ready is low, no input is consumed and out_data holds its value.
- R9: Reset clears err and restarts the epoch count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-input record valid |
| in_ready | output | N | Per-input record accepted |
| in_data | input | N*IW | Input records, input i at bits [i*IW +: IW] |
| out_valid | output | 1 | Merged record valid |
| out_ready | input | 1 | Merged record accepted downstream |
| out_data | output | OW | Merged record, OW = 1+IDX_W+CH_W+OFF_W |
| err | output | 1 | Sticky epoch mismatch flag |

## Verification
The hardest situations to reach are those where the ordering decision spans inputs that sit in different phases. In one, some inputs already wait at the next marker while others still hold hits. In another, two inputs hold hits with equal offsets. The stimulus table staggers the streams so that each of these arises while the output is stalled every third cycle. It then ends with an empty epoch whose marker on one input carries a wrong epoch number. This exercises ordering, tie-breaking, back-to-back markers and the error flag in a single walk.

// File: rtl/hit_merge.sv
module hit_merge #(
  parameter int N     = 4,
  parameter int CH_W  = 6,
  parameter int OFF_W = 8,
  parameter int EP_W  = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int IW    = 1 + CH_W + OFF_W,
  localparam int OW    = 1 + IDX_W + CH_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  output logic [N-1:0]    in_ready,
  input  logic [N*IW-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OW-1:0]   out_data,
  output logic            err
);

  logic [EP_W-1:0]       exp_ep;
  logic [N-1:0]          is_mark;
  logic                  any_bad, found, all_mark, take;
  logic [IDX_W-1:0]      sel;
  logic [OFF_W-1:0]      best;
  logic [CH_W+OFF_W-1:0] sel_body;

  always_comb begin
    any_bad  = 1'b0;
    found    = 1'b0;
    sel      = '0;
    best     = '0;
    sel_body = '0;
    for (int i = 0; i < N; i++) begin
      is_mark[i] = in_data[i*IW + IW - 1];
      if (is_mark[i] && in_data[i*IW +: EP_W] != exp_ep)
        any_bad = 1'b1;
      if (!is_mark[i] && (!found || in_data[i*IW +: OFF_W] < best)) begin
        found    = 1'b1;
        best     = in_data[i*IW +: OFF_W];
        sel      = IDX_W'(i);
        sel_body = in_data[i*IW +: CH_W+OFF_W];
      end
    end
  end

  assign all_mark  = &is_mark;
  assign out_valid = &in_valid;
  assign take      = out_valid & out_ready;
  assign out_data  = all_mark ? {1'b1, {(OW-1-EP_W){1'b0}}, exp_ep}
                              : {1'b0, sel, sel_body};

  always_comb
    for (int i = 0; i < N; i++)
      in_ready[i] = take & (all_mark | (found & (sel == IDX_W'(i))));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      exp_ep <= '0;
      err    <= 1'b0;
    end else if (take && all_mark) begin
      exp_ep <= exp_ep + 1'b1;
      err    <= err | any_bad;
    end

endmodule

module hit_merge_chk #(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int OW    = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          err
);

  a_r2_consume_needs_output: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> (out_valid && out_ready));

  a_r8_no_consume_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (in_ready == '0));

  a_r5_marker_takes_all: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_data[OW-1]) |-> (&in_ready));

  a_r3_hit_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_data[OW-1]) |-> ($countones(in_ready) == 1));

  a_r4_hit_from_tagged_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_data[OW-1]) |-> in_ready[out_data[OW-2 -: IDX_W]]);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind hit_merge hit_merge_chk #(.N(N), .IDX_W(IDX_W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .err(err)
);

// File: tb/tb_hit_merge.sv
module tb_hit_merge;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, CH_W = 6, OFF_W = 8, EP_W = 8, IDX_W = 2;
  localparam int IW = 1 + CH_W + OFF_W;
  localparam int OW = 1 + IDX_W + CH_W + OFF_W;
  localparam int NEXP = 12;

  function automatic logic [IW-1:0] ih(input int c, input int o);
    return {1'b0, c[CH_W-1:0], o[OFF_W-1:0]};
  endfunction
  function automatic logic [IW-1:0] im(input int e);
    return {1'b1, {(IW-1-EP_W){1'b0}}, e[EP_W-1:0]};
  endfunction
  function automatic logic [OW-1:0] oh(input int i, input int c, input int o);
    return {1'b0, i[IDX_W-1:0], c[CH_W-1:0], o[OFF_W-1:0]};
  endfunction
  function automatic logic [OW-1:0] om(input int e);
    return {1'b1, {(OW-1-EP_W){1'b0}}, e[EP_W-1:0]};
  endfunction

  // R1 layouts: per-input streams (padded) and expected merged output
  localparam logic [IW-1:0] SRC [4][8] = '{
    '{im(0), ih(1,10), ih(2,40), im(1), im(2), ih(3,5), im(3), im(4)},
    '{im(0), ih(4,10), im(1), im(2), im(3), im(4), '0, '0},
    '{im(0), ih(5,30), im(1), ih(6,7), im(2), im(3), im(9), '0},
    '{im(0), im(1), ih(7,2), im(2), im(3), im(4), '0, '0}};
  localparam int LEN [4] = '{8, 6, 7, 6};
  localparam logic [OW-1:0] EXP [NEXP] = '{
    om(0), oh(0,1,10), oh(1,4,10), oh(2,5,30), oh(0,2,40), om(1),
    oh(3,7,2), oh(2,6,7), om(2), oh(0,3,5), om(3), om(4)};

  logic clk = 0, rst_n = 0, out_ready = 0, out_valid, err;
  logic [N-1:0] in_valid = '0, in_ready;
  logic [N*IW-1:0] in_data = '0;
  logic [OW-1:0] out_data;

  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_merge #(.N(N), .CH_W(CH_W), .OFF_W(OFF_W), .EP_W(EP_W)) dut (.*);

  task automatic chk(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    int ptr [4];
    int k, cyc;
    logic stall_pend;
    logic [OW-1:0] stall_val;

    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R9 err after reset", OW'(err), OW'(0));
    chk("R2 no valid inputs", OW'(out_valid), OW'(0));
    rst_n = 1;

    @(negedge clk);
    for (int i = 0; i < N; i++) in_data[i*IW +: IW] = im(0);
    in_valid = 4'b0111; out_ready = 1; #1;
    chk("R2 partial valid out_valid", OW'(out_valid), OW'(0));
    chk("R2 partial valid in_ready", OW'(in_ready), OW'(0));
    @(negedge clk); in_valid = '0; out_ready = 0;

    for (int i = 0; i < 4; i++) ptr[i] = 0;
    k = 0; cyc = 0; stall_pend = 0; stall_val = '0;
    while (k < NEXP && cyc < 2000) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        in_valid[i] = ptr[i] < LEN[i];
        in_data[i*IW +: IW] = (ptr[i] < LEN[i]) ? SRC[i][ptr[i]] : '0;
      end
      out_ready = (cyc % 3) != 2;
      #1;
      if (stall_pend && out_valid) begin
        chk("R8 data held across stall", out_data, stall_val);
        stall_pend = 0;
      end
      if (out_valid && !out_ready) begin
        chk("R8 nothing consumed on stall", OW'(in_ready), OW'(0));
        stall_pend = 1; stall_val = out_data;
      end
      if (out_valid && out_ready) begin
        if (k == NEXP-1) chk("R6 err clear before bad marker", OW'(err), OW'(0));
        chk(EXP[k][OW-1] ? "R5/R7 marker" : "R3/R4 hit order", out_data, EXP[k]);
        k++;
      end
      for (int i = 0; i < N; i++)
        if (in_valid[i] && in_ready[i]) ptr[i]++;
      cyc++;
    end
    if (cyc >= 2000) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual %0d outputs expected %0d", k, NEXP);
    end

    @(negedge clk); in_valid = '0; #1;
    chk("R6 err set by mismatched epoch", OW'(err), OW'(1));
    for (int i = 0; i < 4; i++)
      chk("R6 mismatched marker consumed", OW'(ptr[i]), OW'(LEN[i]));

    rst_n = 0;
    @(negedge clk); #1;
    chk("R9 err cleared by reset", OW'(err), OW'(0));
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) in_data[i*IW +: IW] = im(0);
    in_valid = '1; out_ready = 1; #1;
    chk("R9 epoch restarts at zero", out_data, om(0));
    chk("R5 all inputs consumed", OW'(in_ready), OW'(4'b1111));
    @(negedge clk); in_valid = '0; #1;
    chk("R9 no error after restart", OW'(err), OW'(0));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule